// File: doc/BRIEF.md
# Dual 8-Bit Programmable Parallel Port

This block is a bus-attached peripheral with two 8-bit ports, A and B. Each port has a data register and a direction register, and every pin is set to input or output by its own direction bit. An output pin is driven from the data register. An input pin has its driver turned off, and its level is brought into the clock domain through two flip-flops before it can be read.

The host reaches the block through a pair of chip selects, a 4-bit register offset, separate read and write strobes and an 8-bit data path in each direction. The port B data register sits at offset 0 and the port A data register at offset 1. A 16-bit host can therefore fetch both ports in one access, with B in the lower address. The direction registers follow at offsets 2 and 3. Offset 12 is held for a future control register. For now it is plain storage that does not affect the pins. Pin tri-state control is presented as separate output-value and output-enable vectors, so the pad ring can build the bidirectional buffers.

Top module: `par_port_dual`

## Requirements
- R1: The block is selected only when `sel_hi`=1 and `sel_lo_n`=0. With any other combination, a write changes no register, and a read leaves `rdata_oe` low.
- R2: Register offsets are: 0 is the port B data register, 1 is the port A data register, 2 is the port B direction register, and 3 is the port A direction register.
- R3: Direction bit i of a port controls pin i of that same port. A 1 sets `p*_pin_oe[i]`=1, and the pin is driven with data register bit i. A 0 makes the pin an input with its enable low. `p*_pin_o` always shows the port's data register.
- R4: A selected read of a port data offset returns, for each bit, the data register bit where the direction bit is 1 and the synchronized pin level where it is 0.
- R5: An input pin level applied before a clock edge is returned by a read only after the second rising edge that follows it. After only the first edge, the read still returns the previous level.
- R6: Offset 12 is an 8-bit read/write register. It reads back the last value written and has no effect on any pin.
- R7: Offsets 4 to 11 and 13 to 15 read as 0, and writes to them change no readable register and no pin.
- R8: While `rst_n` is low, all data, direction and offset-12 registers are 0, so every pin is an input.
- R9: `rdata_oe` is 1 exactly when the block is selected and `rd_en` is 1. `rdata` is 0 whenever `rdata_oe` is 0.
- R10: A selected read of offset 2 or 3 returns the value last written to that direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| reg_addr | input | 4 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, takes effect on the rising clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| rdata_oe | output | 1 | Bus drive enable for `rdata` |
| pa_pin_i | input | 8 | Port A pin levels |
| pa_pin_o | output | 8 | Port A pin drive values |
| pa_pin_oe | output | 8 | Port A per-pin drive enables |
| pb_pin_i | input | 8 | Port B pin levels |
| pb_pin_o | output | 8 | Port B pin drive values |
| pb_pin_oe | output | 8 | Port B per-pin drive enables |

## Verification
Some checks run on every cycle. These cover the bus drive enable against the two selects and the read strobe, and a quiet `rdata` when the bus is not driven. They also cover writes through each data and direction offset landing on the matching pin vectors one edge later, unselected writes leaving the pins untouched, and the cleared state during reset. Other behaviour only shows up in the bench's scenarios. This includes the per-bit mix of register and pin values on readback, the two-edge delay of the input synchronizer, the storage-only register at offset 12, and the silence of the unused offsets. Those scenarios use random pin levels, directions and select combinations, checked against a bench model.

// File: rtl/par_port_dual.sv
module par_port_dual #(
  parameter int W        = 8,
  parameter int AW       = 4,
  parameter int CTRL_OFS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_hi,
  input  logic          sel_lo_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          rdata_oe,
  input  logic [W-1:0]  pa_pin_i,
  output logic [W-1:0]  pa_pin_o,
  output logic [W-1:0]  pa_pin_oe,
  input  logic [W-1:0]  pb_pin_i,
  output logic [W-1:0]  pb_pin_o,
  output logic [W-1:0]  pb_pin_oe
);
  localparam logic [AW-1:0] OFS_BDAT = AW'(0);
  localparam logic [AW-1:0] OFS_ADAT = AW'(1);
  localparam logic [AW-1:0] OFS_BDIR = AW'(2);
  localparam logic [AW-1:0] OFS_ADIR = AW'(3);
  localparam logic [AW-1:0] OFS_CTRL = AW'(CTRL_OFS);

  logic [W-1:0] a_dat, b_dat, a_dir, b_dir, ctl;
  logic [W-1:0] a_s1, a_s2, b_s1, b_s2;

  wire chip_on = sel_hi & ~sel_lo_n;
  wire wr_go   = chip_on & wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_dat <= '0;
      b_dat <= '0;
      a_dir <= '0;
      b_dir <= '0;
      ctl   <= '0;
    end else if (wr_go) begin
      case (reg_addr)
        OFS_BDAT: b_dat <= wdata;
        OFS_ADAT: a_dat <= wdata;
        OFS_BDIR: b_dir <= wdata;
        OFS_ADIR: a_dir <= wdata;
        OFS_CTRL: ctl   <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_s1 <= '0;
      a_s2 <= '0;
      b_s1 <= '0;
      b_s2 <= '0;
    end else begin
      a_s1 <= pa_pin_i;
      a_s2 <= a_s1;
      b_s1 <= pb_pin_i;
      b_s2 <= b_s1;
    end
  end

  assign pa_pin_o  = a_dat;
  assign pa_pin_oe = a_dir;
  assign pb_pin_o  = b_dat;
  assign pb_pin_oe = b_dir;
  assign rdata_oe  = chip_on & rd_en;

  always_comb begin
    rdata = '0;
    if (rdata_oe) begin
      case (reg_addr)
        OFS_BDAT: rdata = (b_dat & b_dir) | (b_s2 & ~b_dir);
        OFS_ADAT: rdata = (a_dat & a_dir) | (a_s2 & ~a_dir);
        OFS_BDIR: rdata = b_dir;
        OFS_ADIR: rdata = a_dir;
        OFS_CTRL: rdata = ctl;
        default:  rdata = '0;
      endcase
    end
  end

  a_r1_no_drive_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_hi && !sel_lo_n) |-> !rdata_oe);

  a_r1_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(sel_hi && !sel_lo_n)) |=>
      ($stable(pa_pin_o) && $stable(pa_pin_oe) && $stable(pb_pin_o) && $stable(pb_pin_oe)));

  a_r2_adat_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_hi && !sel_lo_n && reg_addr == OFS_ADAT) |=> pa_pin_o == $past(wdata));

  a_r2_bdat_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_hi && !sel_lo_n && reg_addr == OFS_BDAT) |=> pb_pin_o == $past(wdata));

  a_r3_adir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_hi && !sel_lo_n && reg_addr == OFS_ADIR) |=> pa_pin_oe == $past(wdata));

  a_r3_bdir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_hi && !sel_lo_n && reg_addr == OFS_BDIR) |=> pb_pin_oe == $past(wdata));

  a_r8_reset_inputs: assert property (@(posedge clk)
    !rst_n |-> (pa_pin_oe == '0 && pb_pin_oe == '0 && pa_pin_o == '0 && pb_pin_o == '0));

  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '0);
endmodule

// File: tb/par_port_dual_test.sv
module par_port_dual_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       sel_hi = 0, sel_lo_n = 1, rd_en = 0, wr_en = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] wdata = 0, pa_pin_i = 0, pb_pin_i = 0;
  logic [7:0] rdata, pa_pin_o, pa_pin_oe, pb_pin_o, pb_pin_oe;
  logic       rdata_oe;

  int total = 0, bad = 0;
  logic [7:0] m_adat = 0, m_bdat = 0, m_adir = 0, m_bdir = 0, m_ctl = 0;

  always #2.5 clk = ~clk;

  par_port_dual uut (.clk, .rst_n, .sel_hi, .sel_lo_n, .reg_addr, .rd_en, .wr_en,
    .wdata, .rdata, .rdata_oe, .pa_pin_i, .pa_pin_o, .pa_pin_oe, .pb_pin_i,
    .pb_pin_o, .pb_pin_oe);

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0:  return (m_bdat & m_bdir) | (pb_pin_i & ~m_bdir);
      4'd1:  return (m_adat & m_adir) | (pa_pin_i & ~m_adir);
      4'd2:  return m_bdir;
      4'd3:  return m_adir;
      4'd12: return m_ctl;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a < 2) return "R4";
    if (a < 4) return "R10";
    if (a == 12) return "R6";
    return "R7";
  endfunction

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d, input bit hi, input bit lo_n);
    @(negedge clk);
    sel_hi = hi; sel_lo_n = lo_n; reg_addr = a; wdata = d; wr_en = 1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; sel_hi = 0; sel_lo_n = 1;
    if (hi && !lo_n) begin
      case (a)
        4'd0: m_bdat = d;
        4'd1: m_adat = d;
        4'd2: m_bdir = d;
        4'd3: m_adir = d;
        4'd12: m_ctl = d;
        default: ;
      endcase
    end
  endtask

  task automatic bus_rd(input logic [3:0] a, input bit hi, input bit lo_n);
    @(negedge clk);
    sel_hi = hi; sel_lo_n = lo_n; reg_addr = a; rd_en = 1;
    #1;
    if (hi && !lo_n) begin
      chk(rdata_oe === 1'b1, "R9", {7'd0, rdata_oe}, 8'h01);
      chk(rdata === exp_rd(a), tag_of(a), rdata, exp_rd(a));
    end else begin
      chk(rdata_oe === 1'b0, "R1", {7'd0, rdata_oe}, 8'h00);
      chk(rdata === 8'h00, "R9", rdata, 8'h00);
    end
    rd_en = 0; sel_hi = 0; sel_lo_n = 1;
  endtask

  task automatic pins_chk(input string tag);
    chk(pa_pin_o === m_adat, tag, pa_pin_o, m_adat);
    chk(pb_pin_o === m_bdat, tag, pb_pin_o, m_bdat);
    chk(pa_pin_oe === m_adir, tag, pa_pin_oe, m_adir);
    chk(pb_pin_oe === m_bdir, tag, pb_pin_oe, m_bdir);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    pa_pin_i = 8'hA5; pb_pin_i = 8'h3C;
    repeat (3) @(negedge clk);
    pins_chk("R8");
    rst_n = 1;
    idle(); idle();
    bus_rd(4'd0, 1, 0);
    bus_rd(4'd1, 1, 0);
    bus_rd(4'd12, 1, 0);

    // R2 R3: per-offset mapping
    bus_wr(4'd1, 8'h11, 1, 0);
    bus_wr(4'd0, 8'h22, 1, 0);
    bus_wr(4'd3, 8'hF0, 1, 0);
    bus_wr(4'd2, 8'h0F, 1, 0);
    pins_chk("R2");
    bus_rd(4'd1, 1, 0);
    bus_rd(4'd0, 1, 0);

    // R1: every non-enabling select pair
    bus_wr(4'd1, 8'hEE, 0, 0);
    bus_wr(4'd3, 8'hEE, 1, 1);
    bus_wr(4'd0, 8'hEE, 0, 1);
    pins_chk("R1");
    bus_rd(4'd1, 0, 0);
    bus_rd(4'd1, 1, 1);

    // R6: storage only
    bus_wr(4'd12, 8'h5A, 1, 0);
    pins_chk("R6");
    bus_rd(4'd12, 1, 0);

    // R7: unused offsets
    bus_wr(4'd7, 8'hFF, 1, 0);
    bus_wr(4'd15, 8'hFF, 1, 0);
    pins_chk("R7");
    bus_rd(4'd7, 1, 0);
    bus_rd(4'd13, 1, 0);
    bus_rd(4'd12, 1, 0);

    // R5: two-edge synchronizer latency
    bus_wr(4'd3, 8'h00, 1, 0);
    pa_pin_i = 8'h00;
    idle(); idle();
    @(negedge clk); pa_pin_i = 8'hC3;
    @(posedge clk); @(negedge clk);
    sel_hi = 1; sel_lo_n = 0; reg_addr = 4'd1; rd_en = 1; #1;
    chk(rdata === 8'h00, "R5", rdata, 8'h00);
    @(posedge clk); @(negedge clk); #1;
    chk(rdata === 8'hC3, "R5", rdata, 8'hC3);
    rd_en = 0; sel_hi = 0; sel_lo_n = 1;

    // random mix
    for (int it = 0; it < 600; it++) begin
      logic [3:0] a;
      bit hi, lo_n;
      int r;
      pa_pin_i = 8'($urandom); pb_pin_i = 8'($urandom);
      idle(); idle();
      r = $urandom % 8;
      if (r < 6) begin
        int k = $urandom % 5;
        a = (k == 4) ? 4'd12 : 4'(k);
      end else a = 4'($urandom);
      r = $urandom % 4;
      hi = (r == 0) ? 1'($urandom) : 1'b1;
      lo_n = (r == 0) ? 1'($urandom) : 1'b0;
      if ($urandom % 2) bus_wr(a, 8'($urandom), hi, lo_n);
      else bus_rd(a, hi, lo_n);
      pins_chk("R3");
    end

    // R8: reset again clears
    @(negedge clk); rst_n = 0;
    m_adat = 0; m_bdat = 0; m_adir = 0; m_bdir = 0; m_ctl = 0;
    #1; pins_chk("R8");
    @(negedge clk); rst_n = 1;
    idle(); idle();
    bus_rd(4'd12, 1, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule